// File: doc/BRIEF.md
# Programmer host command interpreter

This block sits between a host byte link and the target-side engine of an in-system memory programmer. The host sends single-letter commands, some followed by argument bytes. The block collects those bytes and keeps a 16-bit word address. It sends each memory operation to the engine as one request on a request/acknowledge port, and returns the reply bytes on a byte output stream. Byte framing on the host link and the wire protocol towards the target are both outside the block. Both byte streams use a valid/ready handshake.

Most commands need programming mode. The information commands ('S', 'V', 'v', 't') are always accepted, and device selection ('T') is accepted only while programming mode is off. Entering programming mode ('P') requires a selected device. A refused command, or a letter the block does not know, gets a single '?' and no argument bytes are taken for it.

The controller has five states:
- IDLE waits for a command letter. It goes to ARGS when the letter needs argument bytes, to EXEC when it needs none, and straight to REPLY with '?' when the letter is refused.
- ARGS shifts in argument bytes and goes to EXEC after the last one.
- EXEC applies the local effects: device store, address load, or leaving programming mode. It then goes to REQ when an engine operation is needed, or to REPLY otherwise.
- REQ holds the request until it is acknowledged, captures the returned data and goes to REPLY.
- REPLY sends the reply bytes one per accepted transfer and returns to IDLE after the last byte.

Top module: `prog_cmd_interp`

## Requirements
- R1: After reset, rx_ready is 1 and tx_valid and req_valid are 0. Programming mode is off, no device is selected and the address is 0x0000.
- R2: A refused or unknown command letter is answered with exactly one byte 0x3F. None of its argument bytes are taken, and mode, device and address keep their values.
- R3: 'S' returns the seven ASCII bytes "BYTEPRG". 'V' returns "21" and 'v' returns "10". 't' returns device codes 0x21, 0x32, 0x43, 0x54 followed by 0x00. All four are accepted in any mode.
- R4: 'T' plus one byte stores the device code and replies 0x0D, but only while programming mode is off. 'P' is refused until a device is selected. When accepted, 'P' issues operation 1 with req_arg = {16'h0, device}, turns programming mode on at the acknowledge, and replies 0x0D.
- R5: 'L' turns programming mode off and replies 0x0D. After it, commands that need the mode get 0x3F.
- R6: 'A' plus a high byte and then a low byte loads the address and replies 0x0D.
- R7: 'R' issues operation 4 at the current address. It replies ack_data[15:8] and then ack_data[7:0], and afterwards the address is one higher, wrapping from 0xFFFF to 0x0000.
- R8: 'c' issues operation 2 and 'C' issues operation 3, each with the data byte in req_arg[7:0] and the current address, and each replies 0x0D. Only 'C' advances the address.
- R9: 'D' plus one byte issues operation 5 and replies 0x0D. 'd' issues operation 6 and replies only ack_data[7:0]. Neither changes the address.
- R10: ':' plus three bytes issues operation 9 with the first byte in req_arg[23:16] and the last in req_arg[7:0]. It replies ack_data[7:0] and then 0x0D.
- R11: 'e' issues operation 7 and 'm' issues operation 8, each replying 0x0D after the acknowledge. 'x' and 'y' take one byte, issue nothing and reply 0x0D. 'p' replies 0x53.
- R12: req_valid, req_op, req_addr and req_arg stay stable until req_ack. tx_data stays stable while tx_ready is low. rx_ready is low while a request or a reply is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Host byte present |
| rx_data | input | 8 | Host byte |
| rx_ready | output | 1 | Block takes the host byte this cycle |
| tx_valid | output | 1 | Reply byte present |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Host link takes the reply byte |
| req_valid | output | 1 | Engine operation pending |
| req_op | output | 4 | Operation code (1..9 as in the requirements) |
| req_addr | output | 16 | Word address for the operation |
| req_arg | output | 24 | Argument bytes for the operation |
| req_ack | input | 1 | Engine completes the operation |
| ack_data | input | 16 | Data returned with the acknowledge |

## Verification
Two events can land in the same cycle: the engine acknowledge in the first cycle of REQ, and the capture of read data together with the address increment. The bench provokes this by switching its engine model to a combinational acknowledge. The stream side is stressed at the same time by holding tx_ready low as the first reply byte appears. The check passes when the word is returned most significant byte first, the byte is held steady while the host is stalled, and no host byte is taken until the reply has drained.

// File: rtl/pci_pkg.sv
package pci_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2 * BYTE_W;
    localparam int ARG_W  = 3 * BYTE_W;
    localparam int IDX_W  = 3;

    typedef enum logic [3:0] {
        OP_NONE  = 4'd0,
        OP_ENTER = 4'd1,
        OP_WR_LO = 4'd2,
        OP_WR_HI = 4'd3,
        OP_RD_PG = 4'd4,
        OP_WR_DM = 4'd5,
        OP_RD_DM = 4'd6,
        OP_ERASE = 4'd7,
        OP_PAGE  = 4'd8,
        OP_RAW   = 4'd9
    } op_e;

    typedef enum logic [3:0] {
        RK_CR, RK_QM, RK_WORD, RK_BYTE, RK_BYTE_CR,
        RK_ID, RK_SWV, RK_HWV, RK_DEVS, RK_PTYPE
    } rk_e;

    typedef struct packed {
        logic       known;
        logic       gated;
        logic [1:0] nargs;
        op_e        op;
        rk_e        rk;
    } dec_t;

    function automatic logic [7:0] dev_code(input int i);
        return 8'(8'h10 + 8'h11 * (i + 1));
    endfunction

    function automatic dec_t decode(input logic [7:0] c);
        dec_t d;
        d.known = 1'b1;
        d.gated = 1'b1;
        d.nargs = 2'd0;
        d.op    = OP_NONE;
        d.rk    = RK_CR;
        case (c)
            "P": begin d.op = OP_ENTER; d.gated = 1'b0; end
            "T": begin d.nargs = 2'd1; d.gated = 1'b0; end
            "S": begin d.rk = RK_ID;   d.gated = 1'b0; end
            "V": begin d.rk = RK_SWV;  d.gated = 1'b0; end
            "v": begin d.rk = RK_HWV;  d.gated = 1'b0; end
            "t": begin d.rk = RK_DEVS; d.gated = 1'b0; end
            "L": ;
            "p": d.rk = RK_PTYPE;
            "A": d.nargs = 2'd2;
            "R": begin d.op = OP_RD_PG; d.rk = RK_WORD; end
            "c": begin d.op = OP_WR_LO; d.nargs = 2'd1; end
            "C": begin d.op = OP_WR_HI; d.nargs = 2'd1; end
            "D": begin d.op = OP_WR_DM; d.nargs = 2'd1; end
            "d": begin d.op = OP_RD_DM; d.rk = RK_BYTE; end
            "e": d.op = OP_ERASE;
            "m": d.op = OP_PAGE;
            ":": begin d.op = OP_RAW; d.nargs = 2'd3; d.rk = RK_BYTE_CR; end
            "x", "y": d.nargs = 2'd1;
            default: d.known = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pci_addr_reg.sv
module pci_addr_reg
    import pci_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] din_i,
    input  logic              inc_i,
    output logic [ADDR_W-1:0] addr_o
);

    always_ff @(posedge clk) begin
        if (!rst_n)      addr_o <= '0;
        else if (load_i) addr_o <= din_i;
        else if (inc_i)  addr_o <= addr_o + 1'b1;
    end

    assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !load_i) |=> (addr_o == ADDR_W'($past(addr_o) + 1'b1)));

endmodule

// File: rtl/pci_reply_rom.sv
module pci_reply_rom
    import pci_pkg::*;
#(
    parameter int NUM_DEV = 4,
    parameter int SW_MAJ  = 2,
    parameter int SW_MIN  = 1,
    parameter int HW_MAJ  = 1,
    parameter int HW_MIN  = 0
) (
    input  rk_e              kind_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [15:0]      cap_i,
    output logic [7:0]       byte_o,
    output logic             last_o
);

    localparam logic [55:0] ID_STR = "BYTEPRG";
    localparam int          ID_LEN = 7;

    always_comb begin
        byte_o = 8'h0D;
        last_o = 1'b1;
        case (kind_i)
            RK_QM:    byte_o = 8'h3F;
            RK_PTYPE: byte_o = 8'h53;
            RK_BYTE:  byte_o = cap_i[7:0];
            RK_WORD: begin
                byte_o = (idx_i == '0) ? cap_i[15:8] : cap_i[7:0];
                last_o = (idx_i == IDX_W'(1));
            end
            RK_BYTE_CR: begin
                byte_o = (idx_i == '0) ? cap_i[7:0] : 8'h0D;
                last_o = (idx_i == IDX_W'(1));
            end
            RK_ID: begin
                byte_o = ID_STR[8*(ID_LEN-1-int'(idx_i)) +: 8];
                last_o = (idx_i == IDX_W'(ID_LEN-1));
            end
            RK_SWV: begin
                byte_o = (idx_i == '0) ? 8'(48 + SW_MAJ) : 8'(48 + SW_MIN);
                last_o = (idx_i == IDX_W'(1));
            end
            RK_HWV: begin
                byte_o = (idx_i == '0) ? 8'(48 + HW_MAJ) : 8'(48 + HW_MIN);
                last_o = (idx_i == IDX_W'(1));
            end
            RK_DEVS: begin
                byte_o = (int'(idx_i) < NUM_DEV) ? dev_code(int'(idx_i)) : 8'h00;
                last_o = (idx_i == IDX_W'(NUM_DEV));
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/prog_cmd_interp.sv
module prog_cmd_interp
    import pci_pkg::*;
#(
    parameter int NUM_DEV = 4,
    parameter int SW_MAJ  = 2,
    parameter int SW_MIN  = 1,
    parameter int HW_MAJ  = 1,
    parameter int HW_MIN  = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    output logic        rx_ready,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    input  logic        tx_ready,
    output logic        req_valid,
    output logic [3:0]  req_op,
    output logic [15:0] req_addr,
    output logic [23:0] req_arg,
    input  logic        req_ack,
    input  logic [15:0] ack_data
);

    typedef enum logic [2:0] {ST_IDLE, ST_ARGS, ST_EXEC, ST_REQ, ST_REPLY} st_e;

    st_e              state_q, state_d;
    logic [7:0]       cmd_q;
    logic [1:0]       need_q;
    logic [ARG_W-1:0] arg_q;
    op_e              op_q;
    rk_e              rk_q;
    logic [IDX_W-1:0] idx_q;
    logic [15:0]      cap_q;
    logic             prog_mode, dev_sel;
    logic [7:0]       dev_q;
    dec_t             dec_w;
    logic             allow_w, take_w, last_w, ack_w;

    always_comb dec_w = decode(rx_data);

    assign allow_w = dec_w.known && (!dec_w.gated || prog_mode)
                   && !(rx_data == "T" && prog_mode)
                   && !(rx_data == "P" && !dev_sel);
    assign rx_ready  = (state_q == ST_IDLE) || (state_q == ST_ARGS);
    assign take_w    = rx_valid && rx_ready;
    assign tx_valid  = (state_q == ST_REPLY);
    assign req_valid = (state_q == ST_REQ);
    assign req_op    = op_q;
    assign req_arg   = arg_q;
    assign ack_w     = req_valid && req_ack;

    pci_addr_reg u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (state_q == ST_EXEC && cmd_q == "A"),
        .din_i  (arg_q[ADDR_W-1:0]),
        .inc_i  (ack_w && (cmd_q == "R" || cmd_q == "C")),
        .addr_o (req_addr)
    );

    pci_reply_rom #(
        .NUM_DEV(NUM_DEV), .SW_MAJ(SW_MAJ), .SW_MIN(SW_MIN),
        .HW_MAJ(HW_MAJ), .HW_MIN(HW_MIN)
    ) u_rom (
        .kind_i (rk_q),
        .idx_i  (idx_q),
        .cap_i  (cap_q),
        .byte_o (tx_data),
        .last_o (last_w)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (take_w) state_d = !allow_w ? ST_REPLY :
                                            (dec_w.nargs != 2'd0) ? ST_ARGS : ST_EXEC;
            ST_ARGS:  if (take_w && need_q == 2'd1) state_d = ST_EXEC;
            ST_EXEC:  state_d = (op_q != OP_NONE) ? ST_REQ : ST_REPLY;
            ST_REQ:   if (req_ack) state_d = ST_REPLY;
            ST_REPLY: if (tx_ready && last_w) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath and mode registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            need_q    <= '0;
            arg_q     <= '0;
            op_q      <= OP_NONE;
            rk_q      <= RK_CR;
            idx_q     <= '0;
            cap_q     <= '0;
            prog_mode <= 1'b0;
            dev_sel   <= 1'b0;
            dev_q     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (take_w) begin
                    cmd_q  <= rx_data;
                    need_q <= dec_w.nargs;
                    arg_q  <= '0;
                    idx_q  <= '0;
                    op_q   <= allow_w ? dec_w.op : OP_NONE;
                    rk_q   <= allow_w ? dec_w.rk : RK_QM;
                end
                ST_ARGS: if (take_w) begin
                    arg_q  <= {arg_q[ARG_W-9:0], rx_data};
                    need_q <= need_q - 2'd1;
                end
                ST_EXEC: begin
                    if (cmd_q == "T") begin
                        dev_q   <= arg_q[7:0];
                        dev_sel <= 1'b1;
                    end
                    if (cmd_q == "L") prog_mode <= 1'b0;
                    if (cmd_q == "P") arg_q <= {16'h0, dev_q};
                end
                ST_REQ: if (req_ack) begin
                    cap_q <= ack_data;
                    if (cmd_q == "P") prog_mode <= 1'b1;
                end
                ST_REPLY: if (tx_ready) idx_q <= idx_q + 1'b1;
                default: ;
            endcase
        end
    end

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack) |=> (req_valid && $stable(req_op)
                                     && $stable(req_addr) && $stable(req_arg)));

    assert_tx_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    assert_rx_block_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid || req_valid) |-> !rx_ready);

    assert_deny_qmark_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && take_w && !allow_w) |=> (tx_valid && tx_data == 8'h3F));

    assert_mode_needs_dev_R4: assert property (@(posedge clk) disable iff (!rst_n)
        prog_mode |-> dev_sel);

endmodule

// File: tb/prog_cmd_interp_tb.sv
module prog_cmd_interp_tb;

    typedef struct packed {
        logic [7:0]  cmd;
        logic [1:0]  na;
        logic [23:0] args;
        logic [3:0]  nr;
        logic [63:0] rep;
        logic [3:0]  op;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VEC [NV] = '{
        '{"S", 2'd0, 24'h0, 4'd7, {"BYTEPRG", 8'h00}, 4'd0, 4'd3},           // R3
        '{"V", 2'd0, 24'h0, 4'd2, {"21", 48'h0}, 4'd0, 4'd3},                // R3
        '{"v", 2'd0, 24'h0, 4'd2, {"10", 48'h0}, 4'd0, 4'd3},                // R3
        '{"t", 2'd0, 24'h0, 4'd5, {40'h2132435400, 24'h0}, 4'd0, 4'd3},      // R3
        '{"A", 2'd0, 24'h0, 4'd1, {8'h3F, 56'h0}, 4'd0, 4'd2},               // R2 not in mode
        '{"P", 2'd0, 24'h0, 4'd1, {8'h3F, 56'h0}, 4'd0, 4'd4},               // R4 no device yet
        '{"T", 2'd1, 24'h21, 4'd1, {8'h0D, 56'h0}, 4'd0, 4'd4},              // R4
        '{"P", 2'd0, 24'h0, 4'd1, {8'h0D, 56'h0}, 4'd1, 4'd4},               // R4
        '{"T", 2'd0, 24'h0, 4'd1, {8'h3F, 56'h0}, 4'd0, 4'd4},               // R4 refused in mode
        '{"p", 2'd0, 24'h0, 4'd1, {8'h53, 56'h0}, 4'd0, 4'd11},              // R11
        '{"A", 2'd2, 24'h1234, 4'd1, {8'h0D, 56'h0}, 4'd0, 4'd6},            // R6
        '{"R", 2'd0, 24'h0, 4'd2, {16'hD16E, 48'h0}, 4'd4, 4'd7},            // R7
        '{"R", 2'd0, 24'h0, 4'd2, {16'hD16F, 48'h0}, 4'd4, 4'd7},            // R7
        '{"c", 2'd1, 24'hAB, 4'd1, {8'h0D, 56'h0}, 4'd2, 4'd8},              // R8
        '{"C", 2'd1, 24'hCD, 4'd1, {8'h0D, 56'h0}, 4'd3, 4'd8},              // R8
        '{"R", 2'd0, 24'h0, 4'd2, {16'hD16D, 48'h0}, 4'd4, 4'd8},            // R8 addr 0x1237
        '{"d", 2'd0, 24'h0, 4'd1, {8'h62, 56'h0}, 4'd6, 4'd9},               // R9
        '{"D", 2'd1, 24'h77, 4'd1, {8'h0D, 56'h0}, 4'd5, 4'd9},              // R9
        '{"d", 2'd0, 24'h0, 4'd1, {8'h62, 56'h0}, 4'd6, 4'd9},               // R9 addr kept
        '{":", 2'd3, 24'h300005, 4'd2, {16'h350D, 48'h0}, 4'd9, 4'd10},      // R10
        '{"x", 2'd1, 24'h01, 4'd1, {8'h0D, 56'h0}, 4'd0, 4'd11},             // R11
        '{"y", 2'd1, 24'h00, 4'd1, {8'h0D, 56'h0}, 4'd0, 4'd11},             // R11
        '{"e", 2'd0, 24'h0, 4'd1, {8'h0D, 56'h0}, 4'd7, 4'd11},              // R11
        '{"m", 2'd0, 24'h0, 4'd1, {8'h0D, 56'h0}, 4'd8, 4'd11},              // R11
        '{"Q", 2'd0, 24'h0, 4'd1, {8'h3F, 56'h0}, 4'd0, 4'd2},               // R2 unknown
        '{"L", 2'd0, 24'h0, 4'd1, {8'h0D, 56'h0}, 4'd0, 4'd5},               // R5
        '{"R", 2'd0, 24'h0, 4'd1, {8'h3F, 56'h0}, 4'd0, 4'd5}                // R5 mode left
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, tx_valid, tx_ready = 1'b1;
    logic [7:0]  tx_data;
    logic        req_valid, req_ack;
    logic [3:0]  req_op;
    logic [15:0] req_addr, ack_data;
    logic [23:0] req_arg;

    int          n_chk = 0, n_fail = 0, n_req = 0;
    logic        fast = 1'b0, ack_r = 1'b0;
    logic [1:0]  lat = '0;
    logic [3:0]  last_op = '0;
    logic [15:0] last_addr = '0;
    logic [23:0] last_arg = '0;

    always #5 clk = ~clk;

    prog_cmd_interp u_dut (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_arg(req_arg), .req_ack(req_ack), .ack_data(ack_data)
    );

    // engine model
    assign req_ack  = fast ? req_valid : ack_r;
    assign ack_data = (req_op == 4'd4 || req_op == 4'd6) ? (req_addr ^ 16'hC35A) :
                      (req_op == 4'd9) ? {8'h00, req_arg[23:16] ^ req_arg[7:0]} : 16'h0;

    always @(posedge clk) begin
        ack_r <= 1'b0;
        if (!rst_n) lat <= '0;
        else if (req_valid && !ack_r && !fast) begin
            lat <= lat + 2'd1;
            if (lat == 2'd2) begin ack_r <= 1'b1; lat <= '0; end
        end
        if (req_valid && req_ack) begin
            n_req     <= n_req + 1;
            last_op   <= req_op;
            last_addr <= req_addr;
            last_arg  <= req_arg;
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic get(output logic [7:0] b);
        while (!tx_valid) @(negedge clk);
        b = tx_data;
        @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] c, input int na, input logic [23:0] a,
                        input int nr, output logic [63:0] got);
        logic [7:0] b;
        got = '0;
        put(c);
        for (int k = na - 1; k >= 0; k--) put(a[8*k +: 8]);
        for (int k = 0; k < nr; k++) begin
            get(b);
            got[63-8*k -: 8] = b;
        end
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R12 watchdog act=hung exp=done");
        summary();
        $finish;
    end

    initial begin
        logic [63:0] got;
        int base;
        bit ok;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rx_ready && !tx_valid && !req_valid, "R1 reset outputs",
            {61'h0, rx_ready, tx_valid, req_valid}, 64'h4);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VEC[i];
            base = n_req;
            xfer(v.cmd, int'(v.na), v.args, int'(v.nr), got);
            ok = (got == v.rep) && !tx_valid;
            if (v.op != 4'd0) ok = ok && (n_req == base + 1) && (last_op == v.op);
            else              ok = ok && (n_req == base);
            chk(ok, $sformatf("R%0d vector %0d", v.rq, i), got, v.rep);
        end

        // R1: reset clears device, mode and address
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(rx_ready && !tx_valid && !req_valid, "R1 reset again",
            {61'h0, rx_ready, tx_valid, req_valid}, 64'h4);
        xfer("P", 0, 24'h0, 1, got);
        chk(got[63:56] == 8'h3F, "R1 device cleared", got, {8'h3F, 56'h0});
        xfer("T", 1, 24'h43, 1, got);
        xfer("P", 0, 24'h0, 1, got);
        chk(got[63:56] == 8'h0D && last_op == 4'd1 && last_arg == 24'h000043,
            "R4 enter forwards device", {40'h0, last_arg}, 64'h43);
        xfer("R", 0, 24'h0, 2, got);
        chk(got[63:48] == 16'hC35A, "R1 address zero", got, {16'hC35A, 48'h0});

        // R7: wrap
        xfer("A", 2, 24'hFFFF, 1, got);
        xfer("R", 0, 24'h0, 2, got);
        chk(got[63:48] == 16'h3CA5 && last_addr == 16'hFFFF, "R7 top address", got, {16'h3CA5, 48'h0});
        xfer("R", 0, 24'h0, 2, got);
        chk(got[63:48] == 16'hC35A && last_addr == 16'h0000, "R7 wrap", got, {16'hC35A, 48'h0});

        // R8: write low byte fields
        xfer("c", 1, 24'h5E, 1, got);
        chk(last_op == 4'd2 && last_addr == 16'h0001 && last_arg == 24'h00005E,
            "R8 write fields", {36'h0, last_op, last_addr, last_arg}, {36'h0, 4'd2, 16'h0001, 24'h00005E});

        // R10: byte order of raw command
        xfer(":", 3, 24'h112233, 2, got);
        chk(got[63:48] == 16'h220D && last_arg == 24'h112233, "R10 raw order",
            {got[63:48], 24'h0, last_arg}, {16'h220D, 24'h0, 24'h112233});

        // R12: zero-wait acknowledge with host stall
        fast = 1'b1;
        tx_ready = 1'b0;
        put("R");
        while (!tx_valid) @(negedge clk);
        ok = 1'b1;
        for (int k = 0; k < 3; k++) begin
            if (!(tx_valid && tx_data == 8'hC3 && !rx_ready)) ok = 1'b0;
            @(negedge clk);
        end
        chk(ok, "R12 stall hold", {56'h0, tx_data}, {56'h0, 8'hC3});
        tx_ready = 1'b1;
        begin
            logic [7:0] b0, b1;
            get(b0);
            get(b1);
            chk(b0 == 8'hC3 && b1 == 8'h5B && !tx_valid && last_addr == 16'h0001,
                "R12 fast ack word", {48'h0, b0, b1}, {48'h0, 16'hC35B});
        end
        xfer("R", 0, 24'h0, 2, got);
        chk(got[63:48] == 16'hC35A ^ 16'h0002 && last_addr == 16'h0002, "R7 fast ack increment",
            got, {16'hC358, 48'h0});

        summary();
        $finish;
    end

endmodule